// File: doc/BRIEF.md
# LCD Refresh DMA Controller

This block keeps a monochrome dot-matrix panel refreshed by reading its frame buffer out of system memory, one byte per bus grant, and sending the pixels to an external row/column driver pair over a four-line data path. It takes each byte by raising a bus request to the CPU and waiting for the acknowledge. The CPU answers only between its machine cycles, so a refresh fetch can fall between two machine cycles of a single instruction. The request is dropped right after each byte, which hands the bus back to the CPU between fetches.

The panel side has a frame start pulse, a row latch pulse, a shift clock and a polarity line that flips once per frame. A one-byte prefetch buffer sits between the bus side and the pixel side. When the CPU is slow to grant, the shift clock waits and no stale pixels go out. Bit 3 of the control register is the display enable. Clearing it blanks the panel outputs and stops all memory traffic. Setting it again restarts the refresh from the base address. A separate 5-bit contrast register drives five static pins.

Top module: `lcd_refresh_dma`

## Requirements
- R1: Each fetched byte goes out as two 4-bit groups, bits 7:4 first and then bits 3:0, with lcd_d[3] carrying the most significant bit of the group. Each group comes with a `lcd_scp` pulse one cycle long, and `lcd_d` holds its value through the cycle after that pulse.
- R2: Before the first group of every row, `lcd_lp` is high for one cycle. On row 0 `lcd_fp` is high in that same cycle, and `lcd_fp` is never high without `lcd_lp`.
- R3: `lcd_fr` changes value at the clock edge that raises `lcd_fp`. It therefore alternates from one frame to the next.
- R4: `bus_req` rises only while the prefetch buffer is empty. The byte on `mem_rdata` is taken in a cycle in which both `bus_req` and `bus_ack` are high. `bus_req` is low in the next cycle, and it does not rise again until `bus_ack` has been seen low.
- R5: Fetch addresses run upward from `base_addr`, one per grant. After COLS/8 × ROWS bytes they wrap back to `base_addr`. Row r, byte c is read from base + r·COLS/8 + c.
- R6: While no fetched byte is waiting, no `lcd_scp` pulse is issued. The number of groups sent never exceeds twice the number of grants taken, and a slow grant delays the stream without corrupting it.
- R7: A write with `ctl_we` loads the display enable from bit 3 of `ctl_wdata`, and bits 7:4 and 2:0 have no effect. While the enable is 0, `bus_req` is low from the cycle after the enable register clears. `lcd_d`, `lcd_scp`, `lcd_lp` and `lcd_fp` are low, and `lcd_fr` holds its value.
- R8: When the display is enabled again, the first fetch reads `base_addr` and the first group sent is preceded by a frame pulse.
- R9: A write with `con_we` loads `con_wdata` into the contrast register. `contrast[i]` shows bit i, and the value holds until the next write.
- R10: After reset the display is disabled, the contrast register is 0, and `bus_req` and every panel output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 3 is the display enable |
| con_we | input | 1 | Contrast register write strobe |
| con_wdata | input | 5 | Contrast write data |
| base_addr | input | AW | Frame buffer start address |
| bus_req | output | 1 | Bus request to the CPU |
| bus_ack | input | 1 | Bus acknowledge from the CPU |
| mem_addr | output | AW | Fetch address, valid while the bus is granted |
| mem_rdata | input | 8 | Memory read data |
| lcd_d | output | 4 | Pixel data group |
| lcd_scp | output | 1 | Shift clock pulse |
| lcd_lp | output | 1 | Row latch pulse |
| lcd_fp | output | 1 | Frame start pulse |
| lcd_fr | output | 1 | Frame polarity |
| contrast | output | 5 | Static contrast lines |

## Verification
The buffer can be drained by the pixel side and refilled by a granted fetch in the same cycle, and the two collide hardest when grants are slow. The bench holds `bus_ack` back by several cycles and, in some runs, keeps it high for one cycle after the request falls, which stretches both the handshake and the hand-off. It then checks that the group stream, the row and frame markers and the fetch addresses still match the buffer contents. It also checks that no group is ever sent ahead of the grant that supplied it. A second overlap is a disable that lands in the middle of a fetch or a row. That case is judged by the quiet outputs that follow it and by a clean restart at a new base address.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_REL} fetch_st_t;
  typedef enum logic [2:0] {S_WAIT, S_SYNC, S_HI, S_HIG, S_LO, S_LOG} ser_st_t;
endpackage

// File: rtl/lcdr_regs.sv
module lcdr_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       con_we,
  input  logic [4:0] con_wdata,
  output logic       disp_en,
  output logic [4:0] contrast
);
  logic       en_q, en_d;
  logic [4:0] con_q, con_d;
  logic       unused_ctl;

  assign unused_ctl = ^{ctl_wdata[7:4], ctl_wdata[2:0]};

  always_comb begin
    en_d  = ctl_we ? ctl_wdata[3] : en_q;
    con_d = con_we ? con_wdata : con_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      con_q <= '0;
    end else begin
      en_q  <= en_d;
      con_q <= con_d;
    end
  end

  assign disp_en  = en_q;
  assign contrast = con_q;

  // R9
  contrast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !con_we |=> $stable(contrast));
  // R7
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (disp_en == $past(ctl_wdata[3])));
endmodule

// File: rtl/lcdr_fetch.sv
module lcdr_fetch
  import lcdr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int FRAME_BYTES = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base_addr,
  input  logic          take,
  input  logic          bus_ack,
  input  logic [7:0]    mem_rdata,
  output logic          bus_req,
  output logic [AW-1:0] mem_addr,
  output logic          pf_valid,
  output logic [7:0]    pf_data
);
  localparam int CW = $clog2(FRAME_BYTES);

  fetch_st_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pfv_q, pfv_d;
  logic [7:0]    pfd_q;
  logic          cap;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pfv_d = pfv_q;
    cap   = 1'b0;
    case (st_q)
      F_IDLE: if (en && !pfv_q) st_d = F_REQ;
      F_REQ: begin
        if (!en) begin
          st_d = F_REL;
        end else if (bus_ack) begin
          cap   = 1'b1;
          pfv_d = 1'b1;
          cnt_d = (cnt_q == CW'(FRAME_BYTES - 1)) ? '0 : cnt_q + 1'b1;
          st_d  = F_REL;
        end
      end
      F_REL: if (!bus_ack) st_d = F_IDLE;
      default: st_d = F_IDLE;
    endcase
    if (take) pfv_d = 1'b0;
    if (!en) begin
      cnt_d = '0;
      pfv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= F_IDLE;
      cnt_q <= '0;
      pfv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pfv_q <= pfv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfd_q <= '0;
    else if (cap) pfd_q <= mem_rdata;
  end

  assign bus_req  = (st_q == F_REQ);
  assign mem_addr = base_addr + AW'(cnt_q);
  assign pf_valid = pfv_q;
  assign pf_data  = pfd_q;

  // R4
  one_byte_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);
  // R4
  ack_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_ack) |=> !bus_req);
  // R7
  display_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_req);
  // R4
  req_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !pf_valid);
endmodule

// File: rtl/lcdr_serial.sv
module lcdr_serial
  import lcdr_pkg::*;
#(
  parameter int BPR  = 16,
  parameter int ROWS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pf_valid,
  input  logic [7:0] pf_data,
  output logic       take,
  output logic [3:0] lcd_d,
  output logic       lcd_scp,
  output logic       lcd_lp,
  output logic       lcd_fp,
  output logic       lcd_fr
);
  localparam int COLW = $clog2(BPR);
  localparam int ROWW = $clog2(ROWS);

  ser_st_t         st_q, st_d;
  logic [COLW-1:0] col_q, col_d;
  logic [ROWW-1:0] row_q, row_d;
  logic [7:0]      sh_q, sh_d;
  logic            fr_q, fr_d;

  assign take = en && (st_q == S_WAIT) && pf_valid;

  always_comb begin
    st_d  = st_q;
    col_d = col_q;
    row_d = row_q;
    sh_d  = sh_q;
    fr_d  = fr_q;
    case (st_q)
      S_WAIT: if (pf_valid) begin
        sh_d = pf_data;
        if (col_q == '0) begin
          st_d = S_SYNC;
          if (row_q == '0) fr_d = ~fr_q;
        end else begin
          st_d = S_HI;
        end
      end
      S_SYNC: st_d = S_HI;
      S_HI:   st_d = S_HIG;
      S_HIG:  st_d = S_LO;
      S_LO:   st_d = S_LOG;
      S_LOG: begin
        st_d = S_WAIT;
        if (col_q == COLW'(BPR - 1)) begin
          col_d = '0;
          row_d = (row_q == ROWW'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      default: st_d = S_WAIT;
    endcase
    if (!en) begin
      st_d  = S_WAIT;
      col_d = '0;
      row_d = '0;
      sh_d  = sh_q;
      fr_d  = fr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_WAIT;
      col_q <= '0;
      row_q <= '0;
      sh_q  <= '0;
      fr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      col_q <= col_d;
      row_q <= row_d;
      sh_q  <= sh_d;
      fr_q  <= fr_d;
    end
  end

  always_comb begin
    case (st_q)
      S_HI, S_HIG: lcd_d = sh_q[7:4];
      S_LO, S_LOG: lcd_d = sh_q[3:0];
      default:     lcd_d = 4'h0;
    endcase
  end

  assign lcd_scp = (st_q == S_HI) || (st_q == S_LO);
  assign lcd_lp  = (st_q == S_SYNC);
  assign lcd_fp  = (st_q == S_SYNC) && (row_q == '0);
  assign lcd_fr  = fr_q;

  // R1
  scp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_scp |=> !lcd_scp);
  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_scp && en) |=> $stable(lcd_d));
  // R2
  frame_with_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_fp |-> lcd_lp);
  // R3
  polarity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_fp) |-> (lcd_fr != $past(lcd_fr)));
  // R7
  blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lcd_scp && !lcd_lp && !lcd_fp && lcd_d == 4'h0));
  // R7
  polarity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lcd_fr));
endmodule

// File: rtl/lcd_refresh_dma.sv
module lcd_refresh_dma #(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  parameter int AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          con_we,
  input  logic [4:0]    con_wdata,
  input  logic [AW-1:0] base_addr,
  output logic          bus_req,
  input  logic          bus_ack,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [3:0]    lcd_d,
  output logic          lcd_scp,
  output logic          lcd_lp,
  output logic          lcd_fp,
  output logic          lcd_fr,
  output logic [4:0]    contrast
);
  localparam int BPR         = COLS / 8;
  localparam int FRAME_BYTES = BPR * ROWS;

  logic [1:0] rsync_q;
  logic       rst_i_n;
  logic       disp_en, take, pf_valid;
  logic [7:0] pf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  lcdr_regs u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .con_we(con_we), .con_wdata(con_wdata),
    .disp_en(disp_en), .contrast(contrast)
  );

  lcdr_fetch #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) u_fetch (
    .clk(clk), .rst_n(rst_i_n), .en(disp_en), .base_addr(base_addr),
    .take(take), .bus_ack(bus_ack), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .mem_addr(mem_addr),
    .pf_valid(pf_valid), .pf_data(pf_data)
  );

  lcdr_serial #(.BPR(BPR), .ROWS(ROWS)) u_serial (
    .clk(clk), .rst_n(rst_i_n), .en(disp_en),
    .pf_valid(pf_valid), .pf_data(pf_data), .take(take),
    .lcd_d(lcd_d), .lcd_scp(lcd_scp), .lcd_lp(lcd_lp),
    .lcd_fp(lcd_fp), .lcd_fr(lcd_fr)
  );
endmodule

// File: tb/lcd_refresh_dma_test.sv
module lcd_refresh_dma_test;
  localparam int COLS = 16;
  localparam int ROWS = 4;
  localparam int BPR  = COLS / 8;
  localparam int FB   = BPR * ROWS;
  localparam int LOGN = 2048;
  localparam int NB   = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic        con_we = 1'b0;
  logic [4:0]  con_wdata = 5'h00;
  logic [15:0] base_addr = 16'h0000;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [3:0]  lcd_d;
  logic        lcd_scp, lcd_lp, lcd_fp, lcd_fr;
  logic [4:0]  contrast;

  int vectors = 0, miscompares = 0, cyc = 0;
  int ack_dly = 0, wcnt = 0;
  bit linger = 1'b0, lin_done = 1'b0, disp_on = 1'b0;

  // monitor logs
  logic [3:0]  nib   [LOGN];
  bit          nlp   [LOGN];
  bit          nfp   [LOGN];
  logic [15:0] adr   [LOGN];
  logic        frl   [LOGN];
  int n = 0, m = 0, fcnt = 0, stab_err = 0, r4_err = 0, r6_err = 0;
  bit pend_lp = 0, pend_fp = 0, prev_scp = 0, prev_req = 0, prev_ack = 0;
  logic [3:0] prev_d = 4'h0;

  always #10 clk = ~clk;

  lcd_refresh_dma #(.COLS(COLS), .ROWS(ROWS), .AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .con_we(con_we), .con_wdata(con_wdata), .base_addr(base_addr),
    .bus_req(bus_req), .bus_ack(bus_ack), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .lcd_d(lcd_d), .lcd_scp(lcd_scp),
    .lcd_lp(lcd_lp), .lcd_fp(lcd_fp), .lcd_fr(lcd_fr), .contrast(contrast)
  );

  function automatic logic [7:0] memfn(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd37;
    return t + 8'h1B ^ a[15:8];
  endfunction

  assign mem_rdata = memfn(mem_addr);

  // CPU grant model: acknowledge after ack_dly negedges, optional one-cycle linger
  always @(negedge clk) begin
    if (!bus_req) begin
      if (linger && bus_ack && !lin_done) lin_done = 1'b1;
      else begin bus_ack = 1'b0; lin_done = 1'b0; end
      wcnt = 0;
    end else if (wcnt >= ack_dly) bus_ack = 1'b1;
    else wcnt++;
  end

  // monitor
  always @(negedge clk) begin
    if (!disp_on) begin pend_lp = 0; pend_fp = 0; end
    if (prev_scp && lcd_d != prev_d) stab_err++;
    if (prev_req && prev_ack && bus_req) r4_err++;
    if (!prev_req && prev_ack && bus_req) r4_err++;
    if (bus_req && bus_ack && m < LOGN) begin adr[m] = mem_addr; m++; end
    if (lcd_lp) pend_lp = 1;
    if (lcd_fp) begin
      pend_fp = 1;
      if (fcnt < LOGN) begin frl[fcnt] = lcd_fr; fcnt++; end
    end
    if (lcd_scp && n < LOGN) begin
      nib[n] = lcd_d; nlp[n] = pend_lp; nfp[n] = pend_fp;
      pend_lp = 0; pend_fp = 0; n++;
      if (n > 2 * m) r6_err++;
    end
    prev_scp = lcd_scp; prev_d = lcd_d; prev_req = bus_req; prev_ack = bus_ack;
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < %0d", cyc, 150000);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    disp_on = v[3];
  endtask

  task automatic wait_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  // R10
  task automatic t_reset;
    wait_cycles(4);
    chk(bus_req == 1'b0, "R10", "bus_req after reset", bus_req, 0);
    chk({lcd_d, lcd_scp, lcd_lp, lcd_fp, lcd_fr} == 8'h00, "R10", "panel outputs after reset",
        {lcd_d, lcd_scp, lcd_lp, lcd_fp, lcd_fr}, 0);
    chk(contrast == 5'h00, "R10", "contrast after reset", contrast, 0);
    wait_cycles(20);
    chk(bus_req == 1'b0 && n == 0, "R10", "display disabled after reset", n, 0);
  endtask

  // R9
  task automatic t_contrast;
    @(negedge clk); con_we = 1'b1; con_wdata = 5'b10110;
    @(negedge clk); con_we = 1'b0; con_wdata = 5'b01001;
    chk(contrast == 5'b10110, "R9", "contrast pins after write", contrast, 5'b10110);
    wait_cycles(5);
    chk(contrast == 5'b10110, "R9", "contrast held without write", contrast, 5'b10110);
    chk(contrast[0] == 1'b0 && contrast[4] == 1'b1, "R9", "contrast bit order",
        contrast, 5'b10110);
  endtask

  // R7: bits other than 3 have no effect on the enable
  task automatic t_ignored_bits;
    int n0 = n, m0 = m;
    bit seen_req = 0;
    write_ctl(8'hF7);
    disp_on = 1'b0;
    repeat (40) begin @(negedge clk); if (bus_req || lcd_scp || lcd_lp) seen_req = 1; end
    chk(!seen_req && n == n0 && m == m0, "R7", "enable stays off when bit 3 is 0",
        seen_req, 0);
  endtask

  task automatic run_stream(input logic [15:0] b, input int dly, input bit lin,
                            input bit stall_case);
    int n0, m0, f0, s0, q0, x0, t, bad_d, bad_lp, bad_fp, bad_a, bad_fr;
    int first_bad_d, first_bad_a;
    write_ctl(8'h00);
    wait_cycles(4);
    ack_dly = dly; linger = lin; base_addr = b;
    n0 = n; m0 = m; f0 = fcnt; s0 = stab_err; q0 = r4_err; x0 = r6_err;
    write_ctl(8'h08);
    t = 0;
    while ((n - n0) < NB && t < 30000) begin @(negedge clk); t++; end
    chk((n - n0) >= NB, "R6", "stream progress", n - n0, NB);
    bad_d = 0; bad_lp = 0; bad_fp = 0; bad_a = 0; bad_fr = 0;
    first_bad_d = -1; first_bad_a = -1;
    for (int k = 0; k < NB; k++) begin
      int j = k / 2;
      logic [7:0] eb = memfn(b + 16'(j % FB));
      logic [3:0] en = (k % 2 == 0) ? eb[7:4] : eb[3:0];
      bit elp = (k % 2 == 0) && (j % BPR == 0);
      bit efp = elp && (j % FB == 0);
      if (nib[n0 + k] != en) begin bad_d++; if (first_bad_d < 0) first_bad_d = k; end
      if (nlp[n0 + k] != elp) bad_lp++;
      if (nfp[n0 + k] != efp) bad_fp++;
    end
    if (first_bad_d >= 0)
      chk(1'b0, "R1", "pixel group data", nib[n0 + first_bad_d],
          (first_bad_d % 2 == 0) ? memfn(b + 16'((first_bad_d / 2) % FB)) >> 4
                                 : memfn(b + 16'((first_bad_d / 2) % FB)) & 8'h0F);
    else chk(1'b1, "R1", "pixel group data", 0, 0);
    chk(stab_err == s0, "R1", "data held after shift pulse", stab_err - s0, 0);
    chk(bad_lp == 0, "R2", "row latch placement", bad_lp, 0);
    chk(bad_fp == 0, "R2", "frame pulse placement", bad_fp, 0);
    for (int i = 0; i < NB / 2; i++)
      if (adr[m0 + i] != b + 16'(i % FB)) begin
        bad_a++; if (first_bad_a < 0) first_bad_a = i;
      end
    chk(bad_a == 0, "R5", "fetch address order and wrap",
        (first_bad_a < 0) ? 0 : adr[m0 + first_bad_a],
        (first_bad_a < 0) ? 0 : b + 16'(first_bad_a % FB));
    for (int f = f0 + 1; f < fcnt; f++) if (frl[f] == frl[f - 1]) bad_fr++;
    chk(bad_fr == 0 && (fcnt - f0) >= 3, "R3", "polarity alternates per frame",
        bad_fr, 0);
    chk(r4_err == q0, "R4", "request released after one byte", r4_err - q0, 0);
    if (stall_case)
      chk(r6_err == x0, "R6", "no group ahead of its grant", r6_err - x0, 0);
    chk(adr[m0] == b && nfp[n0], "R8", "restart at base with frame pulse", adr[m0], b);
  endtask

  // R7: disable mid-stream
  task automatic t_disable;
    logic fr0;
    bit noisy = 0;
    wait_cycles(7);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'hF7;
    @(negedge clk); ctl_we = 1'b0; disp_on = 1'b0;
    @(negedge clk);
    fr0 = lcd_fr;
    repeat (40) begin
      @(negedge clk);
      if (bus_req || lcd_scp || lcd_lp || lcd_fp || lcd_d != 4'h0 || lcd_fr != fr0) noisy = 1;
    end
    chk(!noisy, "R7", "outputs quiet and polarity held while off", noisy, 0);
    chk(bus_req == 1'b0, "R7", "no bus request while off", bus_req, 0);
  endtask

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    t_reset();
    t_contrast();
    t_ignored_bits();
    run_stream(16'h0040, 0, 1'b0, 1'b0);
    t_disable();
    run_stream(16'h1230, 5, 1'b1, 1'b1);
    t_disable();
    run_stream(16'h2A08, 2, 1'b0, 1'b1);
    report();
    $finish;
  end
endmodule